// File: doc/BRIEF.md
# Host Command Port Decoder

This block sits behind a single write-only 64-bit port that a simulated or emulated core uses to talk to the host. Each store of 1, 2, 4 or 8 bytes is zero-extended to 64 bits. It is then taken apart into three fields: a target device, an operation code and a 48-bit payload. Two devices are understood: a termination channel that records an exit status, and a character channel that hands one byte to a terminal sink.

On the termination channel, the lowest payload bit asks for termination. The remaining payload bits form the exit status. The done indication raised this way stays up until reset. On the character channel, only the "put" operation produces output: a one-cycle strobe with the byte. The "get" operation is accepted and does nothing. Any other operation or device completes quietly, apart from a one-cycle error pulse for checking. Reads of the port always return zero.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so the port accepts stores from the third rising edge after reset goes high.

Top module: `host_cmd_port`

## Requirements
- R1: While reset is active, and after it, until a store acts: done is 0, exit_code is 0, char_valid is 0, char_data is 0 and unknown_cmd is 0.
- R2: wr_size selects the store width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. Bytes of wr_data above that width are treated as zero before decoding.
- R3: The extended word is decoded as device in bits 63:56, operation in bits 55:48 and payload in bits 47:0. For device 0 with payload bit 0 set, done is 1 from the clock edge that takes the store, and exit_code equals payload bits 47:1, zero-extended.
- R4: A device 0 store with payload bit 0 clear changes neither done nor exit_code, and raises no strobe or error pulse.
- R5: done stays 1 until reset. A later terminating store replaces exit_code with its new value.
- R6: A device 1, operation 1 store gives char_valid high for exactly the one cycle after the edge that takes it, with char_data equal to payload bits 7:0. Back-to-back stores give back-to-back characters.
- R7: A device 1, operation 0 store has no visible effect. A device 1 store with any operation other than 0 or 1 raises only a one-cycle unknown_cmd pulse.
- R8: A store to any device other than 0 or 1 raises only a one-cycle unknown_cmd pulse, and leaves done, exit_code and char_valid unchanged.
- R9: rd_data is always zero.
- R10: In a cycle with no store, char_valid and unknown_cmd are 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Store to the port this cycle |
| wr_size | input | 2 | Store width code (0..3 gives 1, 2, 4 or 8 bytes) |
| wr_data | input | 64 | Store data, low bytes significant |
| rd_data | output | 64 | Read value, always zero |
| done | output | 1 | Sticky termination indication |
| exit_code | output | EXIT_W (64) | Exit status from the last terminating store |
| char_valid | output | 1 | One-cycle strobe for an output character |
| char_data | output | 8 | Character for the terminal sink |
| unknown_cmd | output | 1 | One-cycle pulse for an unrecognised device or operation |

## Verification
The stores include character output with junk in the upper payload bits, which shows that only the low byte reaches the sink. They also include back-to-back characters, which separates a one-cycle strobe from a held level. Narrow stores whose upper bytes would name the character device, if they were not cleared, tell correct zero-extension apart from a pass-through. Device 0 stores with an even payload, a second terminating store and stores to unknown devices and operations separate the sticky done flag, the replaced exit status and the silent paths from the error pulse.

// File: rtl/hcp_pkg.sv
package hcp_pkg;
  localparam int unsigned CMD_W     = 64;
  localparam int unsigned DEV_W     = 8;
  localparam int unsigned OP_W      = 8;
  localparam int unsigned PAY_W     = 48;
  localparam int unsigned SIZE_W    = 2;
  localparam logic [7:0]  DEV_EXIT  = 8'h00;
  localparam logic [7:0]  DEV_TERM  = 8'h01;
  localparam logic [7:0]  OP_GET    = 8'h00;
  localparam logic [7:0]  OP_PUT    = 8'h01;

  // Field order is fixed by the command encoding: device on top.
  typedef struct packed {
    logic [DEV_W-1:0] dev;
    logic [OP_W-1:0]  op;
    logic [PAY_W-1:0] payload;
  } hcp_cmd_t;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_EXIT = 2'd1,
    ACT_CHAR = 2'd2,
    ACT_BAD  = 2'd3
  } hcp_act_t;
endpackage

// File: rtl/hcp_zext.sv
module hcp_zext
  import hcp_pkg::*;
#(
  parameter int unsigned DATA_W = CMD_W
) (
  input  logic [SIZE_W-1:0] size,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out
);
  localparam int unsigned NBYTES = DATA_W / 8;

  logic [31:0] lanes;
  assign lanes = 32'd1 << size;

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    assign data_out[8*i +: 8] = (lanes > 32'(i)) ? data_in[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/hcp_decode.sv
module hcp_decode
  import hcp_pkg::*;
#(
  parameter int unsigned EXIT_W = 64,
  parameter int unsigned CHAR_W = 8
) (
  input  logic              valid,
  input  hcp_cmd_t          cmd,
  output hcp_act_t          act,
  output logic [EXIT_W-1:0] exit_val,
  output logic [CHAR_W-1:0] char_val
);
  assign exit_val = EXIT_W'(cmd.payload[PAY_W-1:1]);
  assign char_val = cmd.payload[CHAR_W-1:0];

  always_comb begin
    act = ACT_NONE;
    if (valid) begin
      unique case (cmd.dev)
        DEV_EXIT: act = cmd.payload[0] ? ACT_EXIT : ACT_NONE;
        DEV_TERM: begin
          if (cmd.op == OP_PUT)      act = ACT_CHAR;
          else if (cmd.op == OP_GET) act = ACT_NONE;
          else                       act = ACT_BAD;
        end
        default:  act = ACT_BAD;
      endcase
    end
  end
endmodule

// File: rtl/hcp_exit_reg.sv
module hcp_exit_reg #(
  parameter int unsigned EXIT_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [EXIT_W-1:0] load_val,
  output logic              done,
  output logic [EXIT_W-1:0] code
);
  logic              done_q, done_d;
  logic [EXIT_W-1:0] code_q, code_d;

  always_comb begin
    done_d = done_q | load_en;
    code_d = load_en ? load_val : code_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      code_q <= '0;
    end else begin
      done_q <= done_d;
      code_q <= code_d;
    end
  end

  assign done = done_q;
  assign code = code_q;
endmodule

// File: rtl/hcp_char_reg.sv
module hcp_char_reg #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              bad,
  input  logic [CHAR_W-1:0] char_in,
  output logic              strobe,
  output logic [CHAR_W-1:0] char_out,
  output logic              err
);
  logic              strobe_q, err_q;
  logic [CHAR_W-1:0] char_q, char_d;

  always_comb begin
    char_d = fire ? char_in : char_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      err_q    <= 1'b0;
      char_q   <= '0;
    end else begin
      strobe_q <= fire;
      err_q    <= bad;
      char_q   <= char_d;
    end
  end

  assign strobe   = strobe_q;
  assign char_out = char_q;
  assign err      = err_q;
endmodule

// File: rtl/host_cmd_port.sv
module host_cmd_port
  import hcp_pkg::*;
#(
  parameter int unsigned EXIT_W = 64,
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_size,
  input  logic [63:0]       wr_data,
  output logic [63:0]       rd_data,
  output logic              done,
  output logic [EXIT_W-1:0] exit_code,
  output logic              char_valid,
  output logic [CHAR_W-1:0] char_data,
  output logic              unknown_cmd
);
  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [CMD_W-1:0]  ext_word;
  hcp_cmd_t          cmd;
  hcp_act_t          act;
  logic [EXIT_W-1:0] exit_val;
  logic [CHAR_W-1:0] char_val;

  hcp_zext #(.DATA_W(CMD_W)) u_zext (
    .size     (wr_size),
    .data_in  (wr_data),
    .data_out (ext_word)
  );

  assign cmd = hcp_cmd_t'(ext_word);

  hcp_decode #(.EXIT_W(EXIT_W), .CHAR_W(CHAR_W)) u_decode (
    .valid    (wr_en),
    .cmd      (cmd),
    .act      (act),
    .exit_val (exit_val),
    .char_val (char_val)
  );

  hcp_exit_reg #(.EXIT_W(EXIT_W)) u_exit (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_en  (act == ACT_EXIT),
    .load_val (exit_val),
    .done     (done),
    .code     (exit_code)
  );

  hcp_char_reg #(.CHAR_W(CHAR_W)) u_char (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .fire     (act == ACT_CHAR),
    .bad      (act == ACT_BAD),
    .char_in  (char_val),
    .strobe   (char_valid),
    .char_out (char_data),
    .err      (unknown_cmd)
  );

  assign rd_data = '0;
endmodule

// File: rtl/hcp_checker.sv
module hcp_checker #(
  parameter int unsigned EXIT_W = 64,
  parameter int unsigned CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_size,
  input logic [63:0]       wr_data,
  input logic              done,
  input logic [EXIT_W-1:0] exit_code,
  input logic              char_valid,
  input logic [CHAR_W-1:0] char_data,
  input logic              unknown_cmd
);
  logic full_wr;
  assign full_wr = wr_en && (wr_size == 2'd3);

  // R3: terminating store sets done and loads the shifted payload
  a_r3_exit_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (full_wr && wr_data[63:56] == 8'h00 && wr_data[0])
      |=> (done && exit_code == EXIT_W'($past(wr_data[47:1]))));

  // R4: even payload on device 0 leaves exit state alone
  a_r4_even_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (full_wr && wr_data[63:56] == 8'h00 && !wr_data[0])
      |=> ($stable(done) && $stable(exit_code) && !char_valid && !unknown_cmd));

  // R5: done is sticky
  a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R6: character strobe carries the low payload byte
  a_r6_char_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (full_wr && wr_data[63:48] == 16'h0101)
      |=> (char_valid && char_data == $past(wr_data[CHAR_W-1:0])));

  // R7: terminal get does nothing
  a_r7_get_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (full_wr && wr_data[63:48] == 16'h0100)
      |=> (!char_valid && !unknown_cmd && $stable(done)));

  // R8: unknown device only pulses the error flag
  a_r8_bad_device: assert property (@(posedge clk) disable iff (!rst_n)
    (full_wr && wr_data[63:56] > 8'h01)
      |=> (unknown_cmd && !char_valid && $stable(done) && $stable(exit_code)));

  // R10: no store, no pulse
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (!char_valid && !unknown_cmd));
endmodule

bind host_cmd_port hcp_checker #(.EXIT_W(EXIT_W), .CHAR_W(CHAR_W)) u_hcp_checker (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .wr_en       (wr_en),
  .wr_size     (wr_size),
  .wr_data     (wr_data),
  .done        (done),
  .exit_code   (exit_code),
  .char_valid  (char_valid),
  .char_data   (char_data),
  .unknown_cmd (unknown_cmd)
);

// File: tb/test_host_cmd_port.sv
module test_host_cmd_port;
  localparam int CLK_P = 10;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_size;
  logic [63:0] wr_data;
  logic [63:0] rd_data;
  logic        done;
  logic [63:0] exit_code;
  logic        char_valid;
  logic [7:0]  char_data;
  logic        unknown_cmd;

  host_cmd_port i_host_cmd_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_size(wr_size),
    .wr_data(wr_data), .rd_data(rd_data), .done(done),
    .exit_code(exit_code), .char_valid(char_valid),
    .char_data(char_data), .unknown_cmd(unknown_cmd)
  );

  typedef struct {
    logic        cv;
    logic [7:0]  ch;
    logic        unk;
    logic        dn;
    logic [63:0] code;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  logic        m_done;
  logic [63:0] m_code;
  logic [7:0]  m_char;
  bit          finished = 0;

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // Monitor: sample a quarter period after each rising edge.
  always @(posedge clk) begin
    #(CLK_P/4);
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_checks++;
      if (char_valid !== e.cv || (e.cv && char_data !== e.ch) ||
          unknown_cmd !== e.unk || done !== e.dn || exit_code !== e.code ||
          rd_data !== 64'h0) begin
        n_fail++;
        $display("FAIL %s: act cv=%0b ch=%h unk=%0b done=%0b code=%h rd=%h exp cv=%0b ch=%h unk=%0b done=%0b code=%h rd=0",
                 e.req, char_valid, char_data, unknown_cmd, done, exit_code, rd_data,
                 e.cv, e.ch, e.unk, e.dn, e.code);
      end
    end
  end

  // Driver: applies a store (or idle cycle) and predicts the result.
  task automatic step(input logic en, input logic [1:0] sz,
                      input logic [63:0] d, input string req);
    exp_t        e;
    logic [63:0] x;
    @(negedge clk);
    wr_en   = en;
    wr_size = sz;
    wr_data = d;
    x = 64'h0;
    for (int b = 0; b < (1 << sz); b++) x[8*b +: 8] = d[8*b +: 8];
    e.cv = 1'b0; e.ch = m_char; e.unk = 1'b0; e.req = req;
    if (en) begin
      if (x[63:56] == 8'h00) begin
        if (x[0]) begin m_done = 1'b1; m_code = {17'h0, x[47:1]}; end
      end else if (x[63:56] == 8'h01) begin
        if (x[55:48] == 8'h01) begin e.cv = 1'b1; m_char = x[7:0]; e.ch = x[7:0]; end
        else if (x[55:48] != 8'h00) e.unk = 1'b1;
      end else e.unk = 1'b1;
    end
    e.dn = m_done; e.code = m_code;
    exp_q.push_back(e);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog: act running exp finished");
    finish_run();
  end

  initial begin
    m_done = 0; m_code = 0; m_char = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_size = 2'd3; wr_data = 64'h0;
    repeat (3) @(negedge clk);
    // R1: reset state
    n_checks++;
    if (done !== 1'b0 || exit_code !== 64'h0 || char_valid !== 1'b0 ||
        char_data !== 8'h0 || unknown_cmd !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: act done=%0b code=%h cv=%0b ch=%h unk=%0b exp all zero",
               done, exit_code, char_valid, char_data, unknown_cmd);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    step(0, 2'd3, 64'h0, "R1");
    step(0, 2'd3, 64'h0101_0000_0000_0041, "R10");        // idle with junk data
    step(1, 2'd3, 64'h0101_ABCD_EF12_3448, "R6");          // 'H', junk high payload
    step(1, 2'd3, 64'h0101_0000_0000_0069, "R6");          // back-to-back
    step(1, 2'd3, 64'h0101_FFFF_FFFF_FF21, "R6");
    step(0, 2'd3, 64'h0, "R6");                            // strobe drops
    step(1, 2'd3, 64'h0100_0000_0000_0041, "R7");          // get: silent
    step(1, 2'd3, 64'h0107_0000_0000_0041, "R7");          // unknown op
    step(1, 2'd3, 64'h5A00_0000_0000_0001, "R8");
    step(1, 2'd3, 64'hFF01_0000_0000_0043, "R8");
    step(1, 2'd3, 64'h0000_0000_0000_1234, "R4");
    step(1, 2'd3, 64'h0033_0000_0000_0010, "R4");
    step(1, 2'd0, 64'hFFFF_FFFF_FFFF_FF02, "R2");          // 1 byte -> 0x02
    step(1, 2'd1, 64'h0101_0000_0000_0046, "R2");          // 2 bytes -> even
    step(1, 2'd3, 64'h0000_0000_0000_0055, "R3");          // exit 0x2a
    step(0, 2'd3, 64'h0, "R5");
    step(1, 2'd3, 64'h00FF_8000_0000_0007, "R5");          // replace code
    step(1, 2'd3, 64'h0000_0000_0000_0000, "R5");          // stays done
    step(1, 2'd2, 64'h0101_0000_0000_0041, "R2");          // 4 bytes -> exit 0x20
    step(1, 2'd3, 64'h0101_0000_0000_007A, "R6");          // chars after done
    step(0, 2'd3, 64'h0, "R9");
    step(0, 2'd3, 64'h0, "R10");
    wait (exp_q.size() == 0);
    @(negedge clk);
    finish_run();
  end
endmodule